// File: doc/BRIEF.md
# Logical Address Allocation Controller

This block picks the 4-bit logical address that a node on a consumer-electronics control bus answers to. It takes the node's device kind, its physical address with a valid flag, and an optional address remembered from earlier operation. Each candidate address for the kind is tried with a header-only probe frame, whose initiator and destination fields both carry the candidate. The first candidate that nobody acknowledges is kept. If every candidate is answered, the node falls back to the unregistered address 15.

Allocation begins on its own once the physical address becomes usable. The physical address is usable when the valid flag is high and the address is not FFFF. Probe frames are handed to a separate bit-level transmitter over a simple request interface. The controller holds the request and the candidate address until the transmitter reports that the frame is finished, together with whether it was acknowledged or failed for another reason. Losing the physical address at any point abandons the search and returns the node to address 15.

Top module: `logical_addr_alloc`

## Requirements
- R1: The candidate lists are fixed per device kind, where devType 1 is recorder, 2 is tuner, 3 is player and 4 is audio. Recorder uses 1, 2, 9. Tuner uses 3, 6, 7, 10. Player uses 4, 8, 11. Audio uses 5. The reserved addresses 12 and 13 never appear on pollAddr or logAddr.
- R2: While a probe is pending, pollReq stays high and pollAddr holds the candidate, until a cycle with pollDone high. A completed probe with pollAcked and pollFail both low keeps that candidate. An acknowledged probe moves on to the next candidate. The result appears on logAddr one cycle after pollDone.
- R3: When every candidate of the kind is acknowledged, logAddr becomes 15.
- R4: While physValid is low or physAddr equals 16'hFFFF, logAddr is 15 and no probe is requested.
- R5: A TV (devType 0) at physical address 0 takes address 0 without probing. A TV at any other physical address probes 14, keeps it if it is free, and otherwise takes 15.
- R6: When prevValid is high and prevAddr is in the kind's list, probing starts at prevAddr and continues around the list in circular order. For example, a tuner with prevAddr 6 probes 6, 7, 10, 3. A remembered address that is not in the list is ignored, and probing starts at the list head.
- R7: When the physical address stops being usable at any time, logAddr returns to 15 and pollReq drops, both on the next cycle. This holds mid-search and after allocation.
- R8: A completed probe with pollFail high is repeated on the same candidate, up to ATTEMPTS tries in total (default 3). After the last try fails, the candidate is treated as taken.
- R9: allocDone is a single-cycle pulse that appears in the same cycle the final logAddr does. unregistered is high exactly when logAddr is 15.
- R10: A devType of 5, 6 or 7 has no candidate list. It results in address 15 without probing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devType | input | 3 | Device kind code |
| physAddr | input | 16 | Physical address, one nibble per level |
| physValid | input | 1 | Physical address is known |
| prevValid | input | 1 | prevAddr holds a remembered address |
| prevAddr | input | 4 | Previously held logical address |
| pollReq | output | 1 | Probe frame request, held until pollDone |
| pollAddr | output | 4 | Initiator and destination of the probe |
| pollDone | input | 1 | Transmitter finished the probe |
| pollAcked | input | 1 | Probe was acknowledged (with pollDone) |
| pollFail | input | 1 | Probe failed for another reason (with pollDone) |
| logAddr | output | 4 | Current logical address |
| unregistered | output | 1 | logAddr is 15 |
| allocDone | output | 1 | One-cycle pulse when allocation settles |

## Verification
Every result is due one clock after the cycle that causes it:
- The first pollReq and pollAddr follow the cycle in which the physical address becomes usable.
- The kept address, or the fallback to 15, follows the cycle with pollDone.
- The forced return to 15 follows the loss of the address.

The bench runs a behavioural model that updates on the same rising edge as the design. It compares pollReq, pollAddr, logAddr, unregistered and allocDone on every falling edge. Because of this, each output is checked exactly in the cycle it is due, never earlier or later.

// File: rtl/lacl_pkg.sv
package lacl_pkg;

  localparam int MAX_CANDS = 4;

  typedef enum logic [2:0] {
    KIND_TV    = 3'd0,
    KIND_REC   = 3'd1,
    KIND_TUNER = 3'd2,
    KIND_PLAY  = 3'd3,
    KIND_AUDIO = 3'd4
  } devKind_e;

  typedef struct packed {
    logic load;
    logic advance;
    logic retry;
    logic keep;
    logic giveUp;
    logic root;
    logic clear;
  } dpCmd_t;

  // number of candidates for a kind (0 = no list)
  function automatic logic [2:0] candCount(input logic [2:0] kind);
    case (kind)
      KIND_TV:    candCount = 3'd1;
      KIND_REC:   candCount = 3'd3;
      KIND_TUNER: candCount = 3'd4;
      KIND_PLAY:  candCount = 3'd3;
      KIND_AUDIO: candCount = 3'd1;
      default:    candCount = 3'd0;
    endcase
  endfunction

  // candidate address at list position idx
  function automatic logic [3:0] candAt(input logic [2:0] kind, input logic [1:0] idx);
    candAt = 4'hF;
    case (kind)
      KIND_TV:    candAt = 4'd14;
      KIND_REC:   case (idx) 2'd0: candAt = 4'd1; 2'd1: candAt = 4'd2; default: candAt = 4'd9; endcase
      KIND_TUNER: case (idx) 2'd0: candAt = 4'd3; 2'd1: candAt = 4'd6; 2'd2: candAt = 4'd7; default: candAt = 4'd10; endcase
      KIND_PLAY:  case (idx) 2'd0: candAt = 4'd4; 2'd1: candAt = 4'd8; default: candAt = 4'd11; endcase
      KIND_AUDIO: candAt = 4'd5;
      default:    candAt = 4'hF;
    endcase
  endfunction

endpackage

// File: rtl/lacl_dp.sv
module lacl_dp
  import lacl_pkg::*;
#(
  parameter int ATTEMPTS = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpCmd_t       cmd,
  input  logic [2:0]   devType,
  input  logic         prevValid,
  input  logic [3:0]   prevAddr,
  output logic [3:0]   candAddr,
  output logic [3:0]   addrOut,
  output logic         lastCand,
  output logic         canRetry,
  output logic         listEmpty
);
  localparam int TW = (ATTEMPTS > 1) ? $clog2(ATTEMPTS) : 1;
  localparam logic [TW-1:0] LAST_TRY = TW'(ATTEMPTS - 1);

  logic [2:0]    kindReg;
  logic [1:0]    startIdx;
  logic [2:0]    offset;
  logic [TW-1:0] tries;
  logic [3:0]    addrReg;

  logic [2:0] count;
  logic [2:0] sum;
  logic [2:0] idx;
  logic [1:0] resumeIdx;

  assign count = candCount(kindReg);
  assign sum   = {1'b0, startIdx} + offset;
  assign idx   = (sum >= count) ? sum - count : sum;
  assign candAddr  = candAt(kindReg, idx[1:0]);
  assign lastCand  = (offset == count - 3'd1);
  assign canRetry  = (tries < LAST_TRY);
  assign listEmpty = (candCount(devType) == 3'd0);
  assign addrOut   = addrReg;

  // position of the remembered address inside the new kind's list
  always_comb begin
    resumeIdx = 2'd0;
    for (int i = 0; i < MAX_CANDS; i++) begin
      if (prevValid && (3'(i) < candCount(devType)) && (candAt(devType, 2'(i)) == prevAddr))
        resumeIdx = 2'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindReg  <= 3'd0;
      startIdx <= 2'd0;
      offset   <= 3'd0;
      tries    <= '0;
      addrReg  <= 4'hF;
    end else begin
      if (cmd.load) begin
        kindReg  <= devType;
        startIdx <= resumeIdx;
        offset   <= 3'd0;
        tries    <= '0;
      end
      if (cmd.advance) begin
        offset <= offset + 3'd1;
        tries  <= '0;
      end
      if (cmd.retry)  tries   <= tries + 1'b1;
      if (cmd.keep)   addrReg <= candAddr;
      if (cmd.root)   addrReg <= 4'd0;
      if (cmd.giveUp || cmd.clear) addrReg <= 4'hF;
    end
  end

  assert_no_reserved_R1: assert property (@(posedge clk) disable iff (!rstN)
    (addrReg != 4'd12) && (addrReg != 4'd13));

  assert_tries_bounded_R8: assert property (@(posedge clk) disable iff (!rstN)
    tries <= LAST_TRY);

endmodule

// File: rtl/lacl_ctrl.sv
module lacl_ctrl
  import lacl_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   physOk,
  input  logic   isRoot,
  input  logic   listEmpty,
  input  logic   lastCand,
  input  logic   canRetry,
  input  logic   pollDone,
  input  logic   pollAcked,
  input  logic   pollFail,
  output dpCmd_t cmd,
  output logic   pollReq,
  output logic   allocDone
);
  typedef enum logic [1:0] {ST_IDLE, ST_POLL, ST_HOLD} state_e;

  state_e state, stateNext;
  logic   doneNext;

  always_comb begin
    stateNext = state;
    cmd       = '0;
    doneNext  = 1'b0;
    if (!physOk) begin
      stateNext = ST_IDLE;
      cmd.clear = 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (isRoot) begin
            cmd.root = 1'b1; doneNext = 1'b1; stateNext = ST_HOLD;
          end else if (listEmpty) begin
            cmd.giveUp = 1'b1; doneNext = 1'b1; stateNext = ST_HOLD;
          end else begin
            cmd.load = 1'b1; stateNext = ST_POLL;
          end
        end
        ST_POLL: begin
          if (pollDone) begin
            if (pollFail && canRetry) begin
              cmd.retry = 1'b1;
            end else if (!pollFail && !pollAcked) begin
              cmd.keep = 1'b1; doneNext = 1'b1; stateNext = ST_HOLD;
            end else if (lastCand) begin
              cmd.giveUp = 1'b1; doneNext = 1'b1; stateNext = ST_HOLD;
            end else begin
              cmd.advance = 1'b1;
            end
          end
        end
        default: stateNext = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      allocDone <= 1'b0;
    end else begin
      state     <= stateNext;
      allocDone <= doneNext;
    end
  end

  assign pollReq = (state == ST_POLL);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    allocDone |=> !allocDone);

  assert_quiet_when_invalid_R4: assert property (@(posedge clk) disable iff (!rstN)
    !physOk |=> !pollReq);

endmodule

// File: rtl/logical_addr_alloc.sv
module logical_addr_alloc
  import lacl_pkg::*;
#(
  parameter int ATTEMPTS = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  devType,
  input  logic [15:0] physAddr,
  input  logic        physValid,
  input  logic        prevValid,
  input  logic [3:0]  prevAddr,
  output logic        pollReq,
  output logic [3:0]  pollAddr,
  input  logic        pollDone,
  input  logic        pollAcked,
  input  logic        pollFail,
  output logic [3:0]  logAddr,
  output logic        unregistered,
  output logic        allocDone
);
  dpCmd_t cmd;
  logic   physOk, isRoot, listEmpty, lastCand, canRetry;

  assign physOk = physValid && (physAddr != 16'hFFFF);
  assign isRoot = (devType == KIND_TV) && (physAddr == 16'h0000);

  lacl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .physOk(physOk), .isRoot(isRoot),
    .listEmpty(listEmpty), .lastCand(lastCand), .canRetry(canRetry),
    .pollDone(pollDone), .pollAcked(pollAcked), .pollFail(pollFail),
    .cmd(cmd), .pollReq(pollReq), .allocDone(allocDone)
  );

  lacl_dp #(.ATTEMPTS(ATTEMPTS)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .devType(devType),
    .prevValid(prevValid), .prevAddr(prevAddr), .candAddr(pollAddr),
    .addrOut(logAddr), .lastCand(lastCand), .canRetry(canRetry),
    .listEmpty(listEmpty)
  );

  assign unregistered = (logAddr == 4'hF);

  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pollReq && !pollDone && physOk) |=> $stable(pollAddr));

  assert_drop_to_unreg_R7: assert property (@(posedge clk) disable iff (!rstN)
    !physOk |=> (logAddr == 4'hF));

endmodule

// File: tb/logical_addr_alloc_bench.sv
module logical_addr_alloc_bench;
  localparam int ATT = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  devType = 3'd0;
  logic [15:0] physAddr = 16'h0000;
  logic        physValid = 1'b0;
  logic        prevValid = 1'b0;
  logic [3:0]  prevAddr = 4'd0;
  logic        pollDone = 1'b0, pollAcked = 1'b0, pollFail = 1'b0;
  logic        pollReq, unregistered, allocDone;
  logic [3:0]  pollAddr, logAddr;

  int checks = 0, errors = 0, cycles = 0;
  int respQ[$];
  int waitCnt = 0;

  // reference model state
  bit mBusy = 0, mHold = 0, mDone = 0;
  int mAddr = 15, mTries = 0;
  int q[$];

  always #5 clk = ~clk;

  logical_addr_alloc #(.ATTEMPTS(ATT)) u_logical_addr_alloc (
    .clk(clk), .rstN(rstN), .devType(devType), .physAddr(physAddr),
    .physValid(physValid), .prevValid(prevValid), .prevAddr(prevAddr),
    .pollReq(pollReq), .pollAddr(pollAddr), .pollDone(pollDone),
    .pollAcked(pollAcked), .pollFail(pollFail), .logAddr(logAddr),
    .unregistered(unregistered), .allocDone(allocDone)
  );

  function automatic void buildList(int kind, ref int lst[$]);
    lst = {};
    case (kind)
      0: lst = '{14};
      1: lst = '{1, 2, 9};
      2: lst = '{3, 6, 7, 10};
      3: lst = '{4, 8, 11};
      4: lst = '{5};
      default: lst = {};
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // behavioural reference, same edge as the design
  always @(posedge clk) begin
    bit ok;
    ok = physValid && (physAddr != 16'hFFFF);
    mDone = 0;
    if (!rstN) begin
      mBusy = 0; mHold = 0; mAddr = 15; q = {};
    end else if (!ok) begin
      mBusy = 0; mHold = 0; mAddr = 15; q = {};
    end else if (!mBusy && !mHold) begin
      if (devType == 0 && physAddr == 0) begin
        mAddr = 0; mDone = 1; mHold = 1;
      end else begin
        int lst[$];
        int k;
        buildList(devType, lst);
        k = 0;
        for (int i = 0; i < lst.size(); i++)
          if (prevValid && lst[i] == prevAddr) k = i;
        q = {};
        for (int i = 0; i < lst.size(); i++) q.push_back(lst[(k + i) % lst.size()]);
        if (q.size() == 0) begin
          mAddr = 15; mDone = 1; mHold = 1;
        end else begin
          mBusy = 1; mTries = 0;
        end
      end
    end else if (mBusy && pollDone) begin
      if (pollFail && mTries < ATT - 1) mTries++;
      else if (!pollFail && !pollAcked) begin
        mAddr = q[0]; mDone = 1; mHold = 1; mBusy = 0;
      end else begin
        void'(q.pop_front());
        mTries = 0;
        if (q.size() == 0) begin
          mAddr = 15; mDone = 1; mHold = 1; mBusy = 0;
        end
      end
    end
  end

  // per-cycle comparison, then transmitter responder
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check(pollReq == mBusy, "R2 pollReq", pollReq, mBusy);
      if (mBusy) check(pollAddr == q[0], "R1 R6 pollAddr", pollAddr, q[0]);
      check(logAddr == mAddr, "R2 logAddr", logAddr, mAddr);
      check(allocDone == mDone, "R9 allocDone", allocDone, mDone);
      check(unregistered == (logAddr == 15), "R9 unregistered", unregistered, logAddr == 15);
      check(pollAddr != 12 && pollAddr != 13, "R1 reserved", pollAddr, 0);
    end
    pollDone = 0; pollAcked = 0; pollFail = 0;
    if (pollReq && !pollDone) begin
      waitCnt++;
      if (waitCnt == 2) begin
        int r;
        r = (respQ.size() > 0) ? respQ.pop_front() : 0;
        pollDone = 1; pollAcked = (r == 1); pollFail = (r == 2);
        waitCnt = 0;
      end
    end else waitCnt = 0;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic alloc(input int kind, input int pa, input bit pv, input int pa4,
                       input int resp[$], input int exp, input string req);
    @(negedge clk);
    devType = 3'(kind); physAddr = 16'(pa); prevValid = pv; prevAddr = 4'(pa4);
    respQ = resp; physValid = 1;
    repeat (60) @(negedge clk);
    check(logAddr == exp, req, logAddr, exp);
    check(unregistered == (exp == 15), req, unregistered, exp == 15);
  endtask

  task automatic release_addr();
    @(negedge clk); physValid = 0;
    repeat (2) @(negedge clk);
    check(logAddr == 15, "R7 after release", logAddr, 15);
    check(!pollReq, "R7 pollReq after release", pollReq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(logAddr == 15, "R9 reset logAddr", logAddr, 15);
    check(!pollReq && !allocDone, "R4 reset idle", pollReq, 0);

    alloc(1, 'h1000, 0, 0, '{1, 0}, 2, "R2 recorder second slot");  release_addr();
    alloc(2, 'h1000, 0, 0, '{1, 1, 1, 1}, 15, "R3 tuner all taken");  release_addr();
    alloc(3, 'hFFFF, 0, 0, '{0}, 15, "R4 FFFF no polling");
    check(!pollReq, "R4 no request", pollReq, 0);               release_addr();
    alloc(0, 'h0000, 0, 0, '{1}, 0, "R5 root TV");               release_addr();
    alloc(0, 'h2000, 0, 0, '{0}, 14, "R5 TV free use");          release_addr();
    alloc(0, 'h2100, 0, 0, '{1}, 15, "R5 TV free use taken");    release_addr();
    alloc(2, 'h1100, 1, 6, '{1, 1, 1, 0}, 3, "R6 tuner wrap");   release_addr();
    alloc(3, 'h1000, 1, 9, '{0}, 4, "R6 foreign prev");          release_addr();
    alloc(3, 'h1000, 0, 0, '{2, 2, 0}, 4, "R8 retry then free"); release_addr();
    alloc(3, 'h1000, 0, 0, '{2, 2, 2, 0}, 8, "R8 retries spent"); release_addr();
    alloc(4, 'h3000, 0, 0, '{0}, 5, "R1 audio");                 release_addr();
    alloc(6, 'h3000, 0, 0, '{0}, 15, "R10 unknown kind");        release_addr();

    // R7: loss in the middle of a search
    @(negedge clk);
    devType = 3'd2; physAddr = 16'h1000; prevValid = 0; respQ = '{1, 1, 1};
    physValid = 1;
    repeat (4) @(negedge clk);
    check(pollReq, "R7 searching", pollReq, 1);
    physValid = 0;
    @(negedge clk);
    check(logAddr == 15 && !pollReq, "R7 mid-search loss", logAddr, 15);
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule